// File: doc/BRIEF.md
# Double-Precision Multiply Sequencer

This block forms the full signed 96-bit product of two 48-bit operands with one 24x24 multiply step per cycle, instead of one wide combinational multiplier. Each operand is presented as a signed upper half and an unsigned lower half of 24 bits. An accumulator steps through four partial products in a fixed order. Between some of the steps it shifts right arithmetically by 24 bits. The result leaves as four 24-bit words on one strobed output, least significant word first.

The sequencer runs only while a mode bit is in force. The bit is bit 6 of an 8-bit control register, which is written with OR, AND or load commands that carry an immediate. A change to that bit reaches the sequencer only after a fixed lag of `MODE_LAT` clock edges. Until the lag has run out, a start request is refused. While the mode is in force, a request for any other arithmetic operation raises an error pulse.

Top module: `dpmul_seq`

## Requirements
- R1: After reset, ctl_value is 0 and mode_active, busy, word_valid, done and err are all 0.
- R2: ctl_cmd is sampled at each rising edge, and ctl_value shows the result after that edge. The encodings are: 0 leaves ctl_value unchanged, 1 ORs ctl_imm into it, 2 ANDs ctl_imm into it, and 3 loads ctl_imm.
- R3: mode_active follows bit 6 of ctl_value with a lag of MODE_LAT edges (default 2). If ctl_value bit 6 changes at edge E, mode_active changes at edge E+MODE_LAT and not before.
- R4: A start is accepted only in these conditions: busy is 0, mode_active is 1, and no change of bit 6 is still in flight. Any other start is ignored, and busy stays 0.
- R5: The operands are captured at the edge that accepts start. Later changes to the operand inputs do not affect the result.
- R6: If start is accepted at edge E0, single-cycle strobes follow in this order. After E0+1: word_idx 0 (DP0). After E0+3: word_idx 1 (DP1). After E0+4: word_idx 2 (DP2). After E0+5: word_idx 3 (DP3), together with done. word_valid is 0 in every other cycle.
- R7: {DP3,DP2,DP1,DP0} equals the signed product of the 48-bit two's-complement values {op1_hi,op1_lo} and {op2_hi,op2_lo}.
- R8: busy is 1 from edge E0 until edge E0+5. A start sampled while busy is 1 is ignored and does not alter the words or the schedule.
- R9: If alu_req is 1 at an edge while mode_active is 1, err is 1 for the following cycle. Otherwise err is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_cmd | input | 2 | Control register command: 0 none, 1 OR, 2 AND, 3 load |
| ctl_imm | input | 8 | Immediate for the control command |
| ctl_value | output | 8 | Current control register value |
| mode_active | output | 1 | Lagged mode bit seen by the sequencer |
| alu_req | input | 1 | Request for some other arithmetic operation |
| start | input | 1 | Start a double-precision multiply |
| op1_hi | input | 24 | Signed upper half of operand 1 |
| op1_lo | input | 24 | Unsigned lower half of operand 1 |
| op2_hi | input | 24 | Signed upper half of operand 2 |
| op2_lo | input | 24 | Unsigned lower half of operand 2 |
| busy | output | 1 | Sequence in progress |
| word_valid | output | 1 | Product word strobe |
| word_idx | output | 2 | Index of the product word (0 = least significant) |
| word_data | output | 24 | Product word |
| done | output | 1 | Last word of the product |
| err | output | 1 | Undefined operation requested while in mode |

## Verification
The product is tried with several operand patterns. Two maximum-negative operands give 2^94, which exposes a wrong sign or a shift that drops the top carry. All-ones lower halves with zero upper halves give the largest unsigned cross terms, which catches a lower half that was treated as signed. Zero operands and a zero factor times a nonzero operand show any residue left in the accumulator from the previous run. Mixed-sign and pseudo-random operands separate the order of the shifts and the pairing of halves in the cross products. Other tests check the fixed word schedule, the mode lag, refused starts and the error pulse at the ports.

// File: rtl/dpm_pkg.sv
package dpm_pkg;
  typedef enum logic [1:0] {
    CTL_NOP  = 2'd0,
    CTL_OR   = 2'd1,
    CTL_AND  = 2'd2,
    CTL_LOAD = 2'd3
  } ctl_cmd_e;

  localparam int unsigned STEPS = 4;
endpackage

// File: rtl/dpm_mode_ctl.sv
module dpm_mode_ctl #(
  parameter int unsigned CTL_W    = 8,
  parameter int unsigned MODE_BIT = 6,
  parameter int unsigned MODE_LAT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cmd,
  input  logic [CTL_W-1:0] imm,
  output logic [CTL_W-1:0] ctl_q,
  output logic             mode_eff,
  output logic             pending
);
  import dpm_pkg::*;

  logic [MODE_LAT-1:0] lag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else begin
      case (ctl_cmd_e'(cmd))
        CTL_OR:   ctl_q <= ctl_q | imm;
        CTL_AND:  ctl_q <= ctl_q & imm;
        CTL_LOAD: ctl_q <= imm;
        default:  ctl_q <= ctl_q;
      endcase
    end
  end

  generate
    if (MODE_LAT == 1) begin : g_lag1
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lag_q <= '0;
        else        lag_q <= ctl_q[MODE_BIT];
      end
    end else begin : g_lagn
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lag_q <= '0;
        else        lag_q <= {lag_q[MODE_LAT-2:0], ctl_q[MODE_BIT]};
      end
    end
  endgenerate

  assign mode_eff = lag_q[MODE_LAT-1];

  // any stage still carrying a different value means a change in flight
  always_comb begin
    pending = (ctl_q[MODE_BIT] != mode_eff);
    for (int i = 0; i < MODE_LAT; i++) begin
      if (lag_q[i] != mode_eff) pending = 1'b1;
    end
  end

  p_mode_moves_only_when_pending_r3: assert property (
    @(posedge clk) disable iff (!rst_n)
    !$stable(mode_eff) |-> $past(pending)
  );
endmodule

// File: rtl/dpm_step_ctl.sv
module dpm_step_ctl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       mode_ok,
  output logic       accept,
  output logic       busy,
  output logic [3:0] step_hot,
  output logic       emit_last
);
  import dpm_pkg::*;

  localparam int unsigned CNT_W = $clog2(STEPS + 2);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(STEPS + 1);

  logic [CNT_W-1:0] cnt_q;

  assign busy   = (cnt_q != '0);
  assign accept = start && mode_ok && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (accept)        cnt_q <= CNT_W'(1);
    else if (cnt_q == LAST) cnt_q <= '0;
    else if (busy)          cnt_q <= cnt_q + CNT_W'(1);
  end

  generate
    for (genvar k = 0; k < STEPS; k++) begin : g_step
      assign step_hot[k] = (cnt_q == CNT_W'(k + 1));
    end
  endgenerate

  assign emit_last = (cnt_q == LAST);

  p_one_event_per_cycle_r6: assert property (
    @(posedge clk) disable iff (!rst_n)
    $onehot0({step_hot, emit_last})
  );

  p_busy_holds_to_end_r8: assert property (
    @(posedge clk) disable iff (!rst_n)
    (busy && !emit_last) |=> busy
  );

  p_step1_after_accept_r6: assert property (
    @(posedge clk) disable iff (!rst_n)
    accept |=> step_hot[0]
  );
endmodule

// File: rtl/dpm_mac_dp.sv
module dpm_mac_dp #(
  parameter int unsigned HW    = 24,
  parameter int unsigned ACC_W = 2 * HW + 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic [3:0]              step_hot,
  input  logic [HW-1:0]           a_hi,
  input  logic [HW-1:0]           a_lo,
  input  logic [HW-1:0]           b_hi,
  input  logic [HW-1:0]           b_lo,
  output logic signed [ACC_W-1:0] acc_q,
  output logic signed [ACC_W-1:0] acc_nxt
);
  localparam int unsigned PW  = 2 * HW + 2;
  localparam int unsigned EXT = ACC_W - PW;

  logic [HW-1:0] ah_q, al_q, bh_q, bl_q;

  function automatic logic signed [PW-1:0] mul_uu(input logic [HW-1:0] x, input logic [HW-1:0] y);
    logic [2*HW-1:0] p;
    p = {{HW{1'b0}}, x} * {{HW{1'b0}}, y};
    return $signed({2'b00, p});
  endfunction

  function automatic logic signed [PW-1:0] mul_su(input logic [HW-1:0] s, input logic [HW-1:0] u);
    logic signed [2*HW:0] p;
    p = $signed(s) * $signed({1'b0, u});
    return {p[2*HW], p};
  endfunction

  function automatic logic signed [PW-1:0] mul_ss(input logic [HW-1:0] x, input logic [HW-1:0] y);
    logic signed [PW-1:0] p;
    p = $signed(x) * $signed(y);
    return p;
  endfunction

  function automatic logic signed [ACC_W-1:0] widen(input logic signed [PW-1:0] v);
    return {{EXT{v[PW-1]}}, v};
  endfunction

  function automatic logic signed [ACC_W-1:0] drop_word(input logic signed [ACC_W-1:0] v);
    return v >>> HW;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ah_q <= '0; al_q <= '0; bh_q <= '0; bl_q <= '0;
    end else if (load) begin
      ah_q <= a_hi; al_q <= a_lo; bh_q <= b_hi; bl_q <= b_lo;
    end
  end

  always_comb begin
    acc_nxt = acc_q;
    unique case (1'b1)
      step_hot[0]: acc_nxt = widen(mul_uu(al_q, bl_q));
      step_hot[1]: acc_nxt = drop_word(acc_q) + widen(mul_su(ah_q, bl_q));
      step_hot[2]: acc_nxt = acc_q + widen(mul_su(bh_q, al_q));
      step_hot[3]: acc_nxt = drop_word(acc_q) + widen(mul_ss(ah_q, bh_q));
      default:     acc_nxt = acc_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_nxt;
  end

  p_no_overflow_r7: assert property (
    @(posedge clk) disable iff (!rst_n)
    $past(step_hot[2]) |-> ((&acc_q[ACC_W-1:2*HW+1]) || !(|acc_q[ACC_W-1:2*HW+1]))
  );
endmodule

// File: rtl/dpmul_seq.sv
module dpmul_seq #(
  parameter int unsigned HW       = 24,
  parameter int unsigned MODE_LAT = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    ctl_cmd,
  input  logic [7:0]    ctl_imm,
  output logic [7:0]    ctl_value,
  output logic          mode_active,
  input  logic          alu_req,
  input  logic          start,
  input  logic [HW-1:0] op1_hi,
  input  logic [HW-1:0] op1_lo,
  input  logic [HW-1:0] op2_hi,
  input  logic [HW-1:0] op2_lo,
  output logic          busy,
  output logic          word_valid,
  output logic [1:0]    word_idx,
  output logic [HW-1:0] word_data,
  output logic          done,
  output logic          err
);
  localparam int unsigned ACC_W = 2 * HW + 8;

  logic                    mode_eff, pending, mode_ok, accept, emit_last;
  logic [3:0]              step_hot;
  logic signed [ACC_W-1:0] acc_q, acc_nxt;

  dpm_mode_ctl #(.CTL_W(8), .MODE_BIT(6), .MODE_LAT(MODE_LAT)) u_mode (
    .clk(clk), .rst_n(rst_n), .cmd(ctl_cmd), .imm(ctl_imm),
    .ctl_q(ctl_value), .mode_eff(mode_eff), .pending(pending)
  );

  assign mode_active = mode_eff;
  assign mode_ok     = mode_eff && !pending;

  dpm_step_ctl u_step (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_ok(mode_ok),
    .accept(accept), .busy(busy), .step_hot(step_hot), .emit_last(emit_last)
  );

  dpm_mac_dp #(.HW(HW), .ACC_W(ACC_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .load(accept), .step_hot(step_hot),
    .a_hi(op1_hi), .a_lo(op1_lo), .b_hi(op2_hi), .b_lo(op2_lo),
    .acc_q(acc_q), .acc_nxt(acc_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_valid <= 1'b0;
      word_idx   <= '0;
      word_data  <= '0;
      done       <= 1'b0;
      err        <= 1'b0;
    end else begin
      err        <= alu_req && mode_eff;
      word_valid <= step_hot[0] || step_hot[2] || step_hot[3] || emit_last;
      done       <= emit_last;
      if (step_hot[0]) begin
        word_idx  <= 2'd0;
        word_data <= acc_nxt[HW-1:0];
      end else if (step_hot[2]) begin
        word_idx  <= 2'd1;
        word_data <= acc_nxt[HW-1:0];
      end else if (step_hot[3]) begin
        word_idx  <= 2'd2;
        word_data <= acc_nxt[HW-1:0];
      end else if (emit_last) begin
        word_idx  <= 2'd3;
        word_data <= acc_q[2*HW-1:HW];
      end
    end
  end

  p_done_with_top_word_r6: assert property (
    @(posedge clk) disable iff (!rst_n)
    done |-> (word_valid && word_idx == 2'd3)
  );

  p_dp1_two_after_dp0_r6: assert property (
    @(posedge clk) disable iff (!rst_n)
    (word_valid && word_idx == 2'd1) |-> ($past(word_valid, 2) && $past(word_idx, 2) == 2'd0)
  );

  p_err_follows_req_r9: assert property (
    @(posedge clk) disable iff (!rst_n)
    (alu_req && mode_active) |=> err
  );

  p_refused_start_r4: assert property (
    @(posedge clk) disable iff (!rst_n)
    (start && !busy && !mode_active) |=> !busy
  );
endmodule

// File: tb/dpmul_seq_test.sv
module dpmul_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  ctl_cmd = 2'd0;
  logic [7:0]  ctl_imm = 8'd0;
  logic [7:0]  ctl_value;
  logic        mode_active;
  logic        alu_req = 1'b0;
  logic        start = 1'b0;
  logic [23:0] op1_hi = '0, op1_lo = '0, op2_hi = '0, op2_lo = '0;
  logic        busy, word_valid, done, err;
  logic [1:0]  word_idx;
  logic [23:0] word_data;

  int n_chk = 0;
  int n_bad = 0;
  int unsigned seed = 32'h1357_2468;

  always #2 clk = ~clk;

  dpmul_seq uut (
    .clk(clk), .rst_n(rst_n), .ctl_cmd(ctl_cmd), .ctl_imm(ctl_imm),
    .ctl_value(ctl_value), .mode_active(mode_active), .alu_req(alu_req),
    .start(start), .op1_hi(op1_hi), .op1_lo(op1_lo), .op2_hi(op2_hi), .op2_lo(op2_lo),
    .busy(busy), .word_valid(word_valid), .word_idx(word_idx), .word_data(word_data),
    .done(done), .err(err)
  );

  task automatic chk(input string tag, input logic [95:0] act, input logic [95:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic ctl_write(input logic [1:0] c, input logic [7:0] v);
    @(negedge clk);
    ctl_cmd = c; ctl_imm = v;
    @(negedge clk);
    ctl_cmd = 2'd0;
  endtask

  task automatic settle_mode();
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [95:0] ref_prod(input logic [47:0] a, input logic [47:0] b);
    logic signed [95:0] sa, sb;
    sa = {{48{a[47]}}, a};
    sb = {{48{b[47]}}, b};
    return sa * sb;
  endfunction

  // one multiply with full schedule check; optional disturbance while busy
  task automatic run_mul(input string tag, input logic [47:0] a, input logic [47:0] b,
                         input bit disturb);
    logic [95:0] got;
    logic [95:0] exp;
    got = '0;
    exp = ref_prod(a, b);
    @(negedge clk);
    {op1_hi, op1_lo} = a; {op2_hi, op2_lo} = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk({tag, " R8 busy after accept"}, 96'(busy), 96'd1);
    if (disturb) begin
      {op1_hi, op1_lo} = ~a; {op2_hi, op2_lo} = 48'h1; // R5
    end
    for (int k = 1; k <= 5; k++) begin
      if (disturb && k == 2) start = 1'b1; // R8 start while busy
      @(negedge clk);
      start = 1'b0;
      case (k)
        1: begin chk({tag, " R6 dp0 strobe"}, {94'(word_valid), word_idx}, {94'd1, 2'd0}); got[23:0] = word_data; end
        2: chk({tag, " R6 gap"}, 96'(word_valid), 96'd0);
        3: begin chk({tag, " R6 dp1 strobe"}, {94'(word_valid), word_idx}, {94'd1, 2'd1}); got[47:24] = word_data; end
        4: begin chk({tag, " R6 dp2 strobe"}, {94'(word_valid), word_idx}, {94'd1, 2'd2}); got[71:48] = word_data; end
        default: begin
          chk({tag, " R6 dp3 strobe"}, {93'(word_valid), done, word_idx}, {93'd1, 1'b1, 2'd3});
          got[95:72] = word_data;
        end
      endcase
      if (k < 5) chk({tag, " R6 no early done"}, 96'(done), 96'd0);
    end
    chk({tag, " R7 product"}, got, exp);
    @(negedge clk);
    chk({tag, " R8 idle after sequence"}, {94'(busy), word_valid, done}, 96'd0);
  endtask

  task automatic t_reset();
    chk("R1 reset state", {88'(ctl_value), 4'd0, mode_active, busy, word_valid, done},
        96'd0);
    chk("R1 reset err", 96'(err), 96'd0);
  endtask

  task automatic t_ctl_ops();
    ctl_write(2'd3, 8'h15); chk("R2 load", 96'(ctl_value), 96'h15);
    ctl_write(2'd1, 8'h82); chk("R2 or",   96'(ctl_value), 96'h97);
    ctl_write(2'd2, 8'hF3); chk("R2 and",  96'(ctl_value), 96'h93);
    ctl_write(2'd0, 8'hFF); chk("R2 nop",  96'(ctl_value), 96'h93);
    ctl_write(2'd3, 8'h00);
    settle_mode();
  endtask

  task automatic t_mode_lag();
    @(negedge clk);
    ctl_cmd = 2'd1; ctl_imm = 8'h40;
    @(negedge clk);
    ctl_cmd = 2'd0;
    chk("R3 bit set, mode still off (E)", {94'(ctl_value[6]), mode_active}, {94'd1, 1'b0});
    @(negedge clk);
    chk("R3 mode off at E+1", 96'(mode_active), 96'd0);
    @(negedge clk);
    chk("R3 mode on at E+2", 96'(mode_active), 96'd1);
    @(negedge clk);
  endtask

  task automatic t_refused_start();
    // mode off: start ignored
    ctl_write(2'd2, 8'hBF);
    settle_mode();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R4 start ignored when mode off", 96'(busy), 96'd0);
    repeat (2) @(negedge clk);
    chk("R4 no word when mode off", 96'(word_valid), 96'd0);
    // change in flight: start right after setting is refused
    @(negedge clk); ctl_cmd = 2'd1; ctl_imm = 8'h40;
    @(negedge clk); ctl_cmd = 2'd0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R4 start ignored during mode lag", 96'(busy), 96'd0);
    settle_mode();
    // clearing in flight while mode_active still 1: refused
    @(negedge clk); ctl_cmd = 2'd2; ctl_imm = 8'hBF;
    @(negedge clk); ctl_cmd = 2'd0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R4 start ignored during mode exit lag", 96'(busy), 96'd0);
    settle_mode();
    ctl_write(2'd1, 8'h40);
    settle_mode();
  endtask

  task automatic t_err();
    @(negedge clk); alu_req = 1'b1;
    @(negedge clk); alu_req = 1'b0;
    chk("R9 err after req in mode", 96'(err), 96'd1);
    @(negedge clk);
    chk("R9 err single cycle", 96'(err), 96'd0);
    ctl_write(2'd2, 8'hBF);
    settle_mode();
    @(negedge clk); alu_req = 1'b1;
    @(negedge clk); alu_req = 1'b0;
    chk("R9 no err out of mode", 96'(err), 96'd0);
    ctl_write(2'd1, 8'h40);
    settle_mode();
  endtask

  task automatic t_products();
    run_mul("pos",        48'h0000_0123_4567, 48'h0000_0089_ABCD, 1'b0);
    run_mul("maxneg",     48'h8000_0000_0000, 48'h8000_0000_0000, 1'b0);
    run_mul("lo ones",    48'h0000_00FF_FFFF, 48'h0000_00FF_FFFF, 1'b0);
    run_mul("zero",       48'h0,              48'h0,              1'b0);
    run_mul("zero x neg", 48'h0,              48'hFFFF_FFFF_FFFF, 1'b0);
    run_mul("mixed sign", 48'hFFFF_FF00_0001, 48'h7FFF_FFFF_FFFF, 1'b0);
    run_mul("neg x neg",  48'hFFFF_FFFF_FFFF, 48'hFFFF_FFFF_FFFF, 1'b0);
    run_mul("disturbed",  48'hC0DE_1234_5678, 48'h3A5A_9ABC_DEF0, 1'b1);
    for (int i = 0; i < 6; i++) begin
      logic [47:0] a, b;
      seed = seed * 32'd1103515245 + 32'd12345; a[47:24] = seed[31:8];
      seed = seed * 32'd1103515245 + 32'd12345; a[23:0]  = seed[31:8];
      seed = seed * 32'd1103515245 + 32'd12345; b[47:24] = seed[31:8];
      seed = seed * 32'd1103515245 + 32'd12345; b[23:0]  = seed[31:8];
      run_mul("random", a, b, 1'b0);
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ctl_ops();
    t_mode_lag();
    t_products();
    t_err();
    t_refused_start();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule